// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block is the small translation cache that sits in front of a page table inside a memory management unit. A requester presents a virtual address. The block splits off the page offset and divides the virtual page number into two fields. The low field selects a set and the high field is compared in parallel against every way of that set. The result is registered and comes back one cycle later. A hit returns the physical page number joined to the unchanged page offset. A miss returns a miss flag together with the virtual page number, so that a page table walker can fetch the entry.

When the walk completes, the walker writes the entry back through a separate fill port. A fill chooses its way in this order:
1. A way of the indexed set that already holds the same tag.
2. The lowest-numbered invalid way of the set.
3. The way named by a round-robin pointer kept for each set.

A single-cycle flush input drops every cached translation.

The default configuration uses 14-bit virtual addresses, 12-bit physical addresses and 64-byte pages. That gives an 8-bit virtual page number and a 6-bit physical page number. The array is 4 sets by 4 ways.

Top module: `xlat_cache`

## Requirements
- R1: After reset, `rsp_valid` is 0 and every lookup misses until an entry has been filled.
- R2: The page offset is `lk_vaddr[5:0]`. The virtual page number is `lk_vaddr[13:6]`. The set is selected by page-number bits [1:0] and the tag is page-number bits [7:2]. An entry hits only when both the set and the tag are equal.
- R3: `rsp_valid` is 1 exactly in the cycle after a cycle with `lk_valid` at 1, and 0 otherwise.
- R4: On a hit, `rsp_hit` is 1 and `rsp_paddr` is {stored physical page number, virtual page offset}.
- R5: On a miss, `rsp_hit` is 0, `rsp_paddr` is 0 and `rsp_vpn` carries the virtual page number of the request.
- R6: A fill to a set that has an invalid way is stored without disturbing any valid entry. All 4 ways of a set can be held at once, and other sets are unaffected.
- R7: A fill to a full set with a new tag replaces the way named by that set's round-robin pointer. The pointer starts at way 0 and advances by one after each such replacement.
- R8: A fill whose page number is already cached rewrites that entry's physical page number in place and evicts nothing.
- R9: A flush invalidates every entry in one cycle and resets the round-robin pointers. A fill in the same cycle as a flush is dropped.
- R10: A lookup in the same cycle as a fill or flush sees the contents as they stood before that cycle.
- R11: At most one way of a set matches any lookup. If more than one did, the lowest-numbered way would be used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | VA_W (14) | Virtual address to translate |
| fill_valid | input | 1 | Fill request strobe |
| fill_vpn | input | VA_W-PAGE_BITS (8) | Page number being filled |
| fill_ppn | input | PA_W-PAGE_BITS (6) | Physical page number for the fill |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_paddr | output | PA_W (12) | Translated physical address, 0 on miss |
| rsp_vpn | output | VA_W-PAGE_BITS (8) | Page number of the answered request |

## Verification
The round-robin replacement is the hardest behaviour to reach from the ports. It only shows once a set is completely full of distinct tags. The stimulus therefore fills four page numbers that share set 0 and then adds a fifth and a sixth. Lookups then show exactly which older entries were evicted and in what order. An in-place rewrite of a surviving tag follows, which must leave every neighbour intact. Same-cycle collisions (a lookup against a fill, and a fill against a flush) are produced by driving both strobes in a single cycle and reading the result back with ordinary lookups.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   // index of lowest set bit among the first n bits, 0 when none
   function automatic int lowest_one(input logic [15:0] v, input int n);
      int r;
      r = 0;
      for (int i = n - 1; i >= 0; i--) begin
         if (v[i]) r = i;
      end
      return r;
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/xlat_store.sv
module xlat_store #(
   parameter int SETS  = 4,
   parameter int WAYS  = 4,
   parameter int TAG_W = 6,
   parameter int PPN_W = 6,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    clr,
   input  logic                                    wr_en,
   input  logic [SET_W-1:0]                        wr_set,
   input  logic [WAY_W-1:0]                        wr_way,
   input  logic [TAG_W-1:0]                        wr_tag,
   input  logic [PPN_W-1:0]                        wr_ppn,
   output logic [SETS-1:0][WAYS-1:0]               vld_q,
   output logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]    tag_q,
   output logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]    ppn_q
);

   for (genvar s = 0; s < SETS; s++) begin : g_set
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         logic sel;
         assign sel = wr_en && (wr_set == SET_W'(s)) && (wr_way == WAY_W'(w));

         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               vld_q[s][w] <= 1'b0;
            end else if (sel) begin
               vld_q[s][w] <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tag_q[s][w] <= '0;
               ppn_q[s][w] <= '0;
            end else if (sel && !clr) begin
               tag_q[s][w] <= wr_tag;
               ppn_q[s][w] <= wr_ppn;
            end
         end
      end
   end

   // R9: flush empties the whole array by the next cycle
   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (vld_q == '0));

   // R6: a written way is valid afterwards
   a_r6_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr) |=> vld_q[$past(wr_set)][$past(wr_way)]);

endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 6,
   parameter int PPN_W = 6,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [WAYS-1:0]             vld,
   input  logic [WAYS-1:0][TAG_W-1:0]  tags,
   input  logic [WAYS-1:0][PPN_W-1:0]  ppns,
   input  logic [TAG_W-1:0]            key,
   output logic                        hit,
   output logic [WAY_W-1:0]            hit_way,
   output logic [PPN_W-1:0]            hit_ppn
);
   import xlat_pkg::*;

   logic [WAYS-1:0] eq;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign eq[w] = vld[w] && (tags[w] == key);
   end

   logic [15:0] eq_ext;
   assign eq_ext = 16'(eq);

   always_comb begin
      hit     = |eq;
      hit_way = WAY_W'(lowest_one(eq_ext, WAYS));
      hit_ppn = ppns[hit_way];
   end

   // R11: no two ways of a set may carry the same valid tag
   a_r11_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(eq));

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int SETS = 4,
   parameter int WAYS = 4,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              commit,
   input  logic [SET_W-1:0]  set_sel,
   input  logic [WAYS-1:0]   set_vld,
   input  logic              tag_hit,
   input  logic [WAY_W-1:0]  tag_way,
   output logic [WAY_W-1:0]  victim
);
   import xlat_pkg::*;

   logic [SETS-1:0][WAY_W-1:0] rr_q;
   logic                       full;
   logic [15:0]                free_ext;

   assign full     = &set_vld;
   assign free_ext = 16'(~set_vld);

   always_comb begin
      if (tag_hit)   victim = tag_way;
      else if (!full) victim = WAY_W'(lowest_one(free_ext, WAYS));
      else           victim = rr_q[set_sel];
   end

   for (genvar s = 0; s < SETS; s++) begin : g_rr
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            rr_q[s] <= '0;
         end else if (commit && !tag_hit && full && (set_sel == SET_W'(s))) begin
            rr_q[s] <= rr_q[s] + 1'b1;
         end
      end
   end

   // R7: a full set with no tag match takes the pointer's way
   a_r7_rr_victim: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !tag_hit && full) |-> (victim == rr_q[set_sel]));

   // R6: a set with a free way never evicts a valid entry
   a_r6_free_first: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !tag_hit && !full) |-> !set_vld[victim]);

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
   parameter int VA_W      = 14,
   parameter int PA_W      = 12,
   parameter int PAGE_BITS = 6,
   parameter int SETS      = 4,
   parameter int WAYS      = 4,
   localparam int VPN_W = VA_W - PAGE_BITS,
   localparam int PPN_W = PA_W - PAGE_BITS,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS),
   localparam int TAG_W = VPN_W - SET_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [VA_W-1:0]  lk_vaddr,
   input  logic             fill_valid,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             flush,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic [VPN_W-1:0] rsp_vpn
);
   import xlat_pkg::*;

   // elaboration-time parameter checks
   if (!is_pow2(SETS) || SETS < 2) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (!is_pow2(WAYS) || WAYS < 2 || WAYS > 16) begin : g_bad_ways
      $error("WAYS must be a power of two between 2 and 16");
   end
   if (PA_W <= PAGE_BITS || VA_W <= PAGE_BITS + SET_W) begin : g_bad_widths
      $error("address widths too small for page and set fields");
   end

   // R2: field split
   logic [PAGE_BITS-1:0] lk_off;
   logic [VPN_W-1:0]     lk_vpn;
   logic [SET_W-1:0]     lk_set, fl_set;
   logic [TAG_W-1:0]     lk_tag, fl_tag;

   assign lk_off = lk_vaddr[PAGE_BITS-1:0];
   assign lk_vpn = lk_vaddr[VA_W-1:PAGE_BITS];
   assign lk_set = lk_vpn[SET_W-1:0];
   assign lk_tag = lk_vpn[VPN_W-1:SET_W];
   assign fl_set = fill_vpn[SET_W-1:0];
   assign fl_tag = fill_vpn[VPN_W-1:SET_W];

   logic [SETS-1:0][WAYS-1:0]             vld_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
   logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]  ppn_q;

   logic             wr_en;
   logic [WAY_W-1:0] wr_way;

   assign wr_en = fill_valid && !flush;

   xlat_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (flush),
      .wr_en  (wr_en),
      .wr_set (fl_set),
      .wr_way (wr_way),
      .wr_tag (fl_tag),
      .wr_ppn (fill_ppn),
      .vld_q  (vld_q),
      .tag_q  (tag_q),
      .ppn_q  (ppn_q)
   );

   // lookup path
   logic             lk_hit;
   logic [WAY_W-1:0] lk_way;
   logic [PPN_W-1:0] lk_ppn;

   xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_lk_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (vld_q[lk_set]),
      .tags    (tag_q[lk_set]),
      .ppns    (ppn_q[lk_set]),
      .key     (lk_tag),
      .hit     (lk_hit),
      .hit_way (lk_way),
      .hit_ppn (lk_ppn)
   );

   // fill path: search the target set for an existing copy of the tag
   logic             fl_hit;
   logic [WAY_W-1:0] fl_way;
   logic [PPN_W-1:0] fl_ppn_old;

   xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_fl_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (vld_q[fl_set]),
      .tags    (tag_q[fl_set]),
      .ppns    (ppn_q[fl_set]),
      .key     (fl_tag),
      .hit     (fl_hit),
      .hit_way (fl_way),
      .hit_ppn (fl_ppn_old)
   );

   xlat_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (flush),
      .commit  (wr_en),
      .set_sel (fl_set),
      .set_vld (vld_q[fl_set]),
      .tag_hit (fl_hit),
      .tag_way (fl_way),
      .victim  (wr_way)
   );

   // registered response
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_paddr <= '0;
         rsp_vpn   <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= lk_valid && lk_hit;
         if (lk_valid) begin
            rsp_vpn   <= lk_vpn;
            rsp_paddr <= lk_hit ? {lk_ppn, lk_off} : '0;
         end
      end
   end

   // R3: one response per request, one cycle later
   a_r3_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);
   a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid);

   // R4: the offset passes through untouched on a hit
   a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_hit) |=> (rsp_paddr[PAGE_BITS-1:0] == $past(lk_off)));

   // R5: a miss reports the request's page number
   a_r5_miss_vpn: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (rsp_vpn == $past(lk_vpn)));

   // R8: an in-place rewrite keeps the set's occupancy
   a_r8_inplace: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && fl_hit) |=> $stable(vld_q));

endmodule

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [13:0] lk_vaddr = '0;
   logic        fill_valid = 1'b0;
   logic [7:0]  fill_vpn = '0;
   logic [5:0]  fill_ppn = '0;
   logic        flush = 1'b0;
   logic        rsp_valid, rsp_hit;
   logic [11:0] rsp_paddr;
   logic [7:0]  rsp_vpn;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   xlat_cache dut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_paddr(rsp_paddr), .rsp_vpn(rsp_vpn)
   );

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   // one clock with any mix of strobes; returns with outputs of that edge stable
   task automatic cycle(input bit lk, input logic [13:0] va, input bit fl,
                        input logic [7:0] fv, input logic [5:0] fp, input bit fs);
      @(negedge clk);
      lk_valid = lk; lk_vaddr = va;
      fill_valid = fl; fill_vpn = fv; fill_ppn = fp;
      flush = fs;
      @(negedge clk);
      lk_valid = 1'b0; fill_valid = 1'b0; flush = 1'b0;
   endtask

   task automatic fill(input logic [7:0] v, input logic [5:0] p);
      cycle(0, '0, 1, v, p, 0);
   endtask

   task automatic expect_hit(input string req, input logic [7:0] v, input logic [5:0] off,
                             input logic [5:0] p);
      cycle(1, {v, off}, 0, '0, '0, 0);
      check(req, rsp_valid, 1);
      check(req, rsp_hit, 1);
      check(req, rsp_paddr, {p, off});
   endtask

   task automatic expect_miss(input string req, input logic [7:0] v);
      cycle(1, {v, 6'h2A}, 0, '0, '0, 0);
      check(req, rsp_hit, 0);
      check(req, rsp_paddr, 0);
      check(req, rsp_vpn, v);
   endtask

   task automatic t_reset;
      check("R1 rsp_valid after reset", rsp_valid, 0);
      expect_miss("R1/R5 empty miss", 8'h0F);
      @(negedge clk);
      check("R3 idle cycle no response", rsp_valid, 0);
   endtask

   task automatic t_first_hit;
      fill(8'h0F, 6'h0D);
      expect_hit("R4 hit 0x03D4", 8'h0F, 6'h14, 6'h0D);
      check("R4 paddr 0x354", rsp_paddr, 12'h354);
      expect_miss("R2 same set other tag", 8'h0B);
      expect_miss("R2 same tag other set", 8'h0C);
   endtask

   task automatic t_fill_set;
      fill(8'h00, 6'h20); fill(8'h04, 6'h21);
      fill(8'h08, 6'h22); fill(8'h0C, 6'h23);
      expect_hit("R6 way a", 8'h00, 6'h01, 6'h20);
      expect_hit("R6 way b", 8'h04, 6'h3F, 6'h21);
      expect_hit("R6 way c", 8'h08, 6'h00, 6'h22);
      expect_hit("R6 way d", 8'h0C, 6'h10, 6'h23);
      expect_hit("R6 other set kept", 8'h0F, 6'h05, 6'h0D);
   endtask

   task automatic t_round_robin;
      fill(8'h10, 6'h24);
      expect_miss("R7 first victim evicted", 8'h00);
      expect_hit("R7 new entry", 8'h10, 6'h02, 6'h24);
      expect_hit("R7 survivor", 8'h04, 6'h02, 6'h21);
      fill(8'h14, 6'h25);
      expect_miss("R7 second victim evicted", 8'h04);
      expect_hit("R7 survivor c", 8'h08, 6'h02, 6'h22);
      expect_hit("R7 survivor d", 8'h0C, 6'h02, 6'h23);
   endtask

   task automatic t_inplace;
      fill(8'h08, 6'h3F);
      expect_hit("R8 rewritten", 8'h08, 6'h07, 6'h3F);
      expect_hit("R8 neighbour d", 8'h0C, 6'h07, 6'h23);
      expect_hit("R8 neighbour e", 8'h10, 6'h07, 6'h24);
      expect_hit("R8 neighbour f", 8'h14, 6'h07, 6'h25);
   endtask

   task automatic t_collide;
      cycle(1, {8'h21, 6'h09}, 1, 8'h21, 6'h11, 0);
      check("R10 lookup sees old state", rsp_hit, 0);
      expect_hit("R10 fill landed", 8'h21, 6'h09, 6'h11);
      cycle(1, {8'h21, 6'h09}, 0, '0, '0, 1);
      check("R10 lookup beside flush", rsp_hit, 1);
   endtask

   task automatic t_flush;
      fill(8'h21, 6'h11);
      cycle(0, '0, 1, 8'h22, 6'h12, 1);
      expect_miss("R9 flushed set3", 8'h0F);
      expect_miss("R9 flushed set0", 8'h10);
      expect_miss("R9 flushed set1", 8'h21);
      expect_miss("R9 fill dropped", 8'h22);
      fill(8'h30, 6'h01);
      expect_hit("R9 refill after flush", 8'h30, 6'h3C, 6'h01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_first_hit;
      t_fill_set;
      t_round_robin;
      t_inplace;
      t_collide;
      t_flush;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule